// File: doc/BRIEF.md
# Serial Link Endpoint With Per-Byte Acknowledge

This block is one end of a point-to-point link made of two one-directional serial wires. On its outgoing wire it sends the bytes of a message taken from a byte source. After each byte it waits for the far end to acknowledge that byte before it sends the next. On its incoming wire it decodes data frames and hands the bytes to a byte sink through a one-byte buffer. It answers each incoming byte with a short acknowledge frame, which shares the outgoing wire with outgoing data.

A message starts with a one-cycle start strobe and a byte count. The block then pulls exactly that many bytes from the source with a valid/ready handshake. It raises a one-cycle done pulse once the final byte's acknowledge has come back. The acknowledge for an incoming byte goes out as soon as the frame's second bit shows it is data, and not when the byte is complete. This lets the far end fetch its next byte while the current one is still on the wire, so bytes can follow each other with no gap. All line activity advances on a shared one-bit-per-pulse enable, `bit_tick`.

Top module: `slink_port`

## Requirements
- R1: The line idles low: `line_out` is low during reset and between frames, and after reset `msg_done`, `sink_valid` and `src_ready` are low.
- R2: A data frame is a high start bit, a high type bit, DATA_W data bits least significant first, then a low stop bit. `line_out` moves one bit per `bit_tick` and changes only on a clock edge where `bit_tick` is high.
- R3: After a data frame starts, no further data frame starts on `line_out` until an acknowledge frame has been received on `line_in`.
- R4: An acknowledge frame is a high start bit followed by a low type bit. When no earlier acknowledged byte is waiting for the sink, the acknowledge starts on the tick where the incoming type bit is seen, so it completes before the incoming data frame ends.
- R5: While an acknowledged byte has not yet been accepted by the sink, the acknowledge for a newly arriving byte is withheld until that acceptance. At most one acknowledged byte is ever unaccepted.
- R6: `msg_done` pulses once per message, one cycle after the acknowledge for the final byte is received. A start with count 0 pulses `msg_done` on the next cycle and sends no frame.
- R7: When an acknowledge and a data byte are both waiting for the wire, the acknowledge goes first. A frame that has started is never interrupted, so both directions can carry messages at once.
- R8: A message takes exactly `msg_len` bytes from the source, in source order. A start strobe while a message is in progress is ignored.
- R9: Received bytes reach the sink in arrival order, and `sink_data` stays stable while `sink_valid` is high and `sink_ready` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_tick | input | 1 | Bit-rate enable, one line bit per high cycle |
| line_in | input | 1 | Incoming serial wire |
| line_out | output | 1 | Outgoing serial wire |
| msg_start | input | 1 | One-cycle strobe that starts a message |
| msg_len | input | CNT_W | Byte count of the message, sampled with `msg_start` |
| src_valid | input | 1 | Source offers a byte |
| src_data | input | DATA_W | Byte offered by the source |
| src_ready | output | 1 | Block takes the offered byte |
| sink_valid | output | 1 | A received byte is available |
| sink_data | output | DATA_W | Received byte |
| sink_ready | input | 1 | Sink accepts the byte |
| msg_done | output | 1 | One-cycle pulse when the final byte is acknowledged |

## Verification
On every cycle, the bound checker enforces the per-cycle rules. Only one data frame may be unacknowledged, and an acknowledge and a data frame never start on the same tick. It also checks the single-credit rule of the receive buffer and holds the sink stable under back-pressure. Line edges must fall on bit ticks, and every done pulse must follow an acknowledge or a zero-length start. Frame layout, the delivered byte values and their order, and the early timing of acknowledges can only be shown by the bench's scenarios. The same holds for withholding acknowledges under a stalled sink, ignoring a second start, and two-way traffic. In those scenarios, two endpoints are wired back to back and both wires are decoded bit by bit.

// File: rtl/slink_pkg.sv
package slink_pkg;

  typedef enum logic [1:0] {RX_IDLE, RX_TYPE, RX_DATA, RX_STOP} rx_state_e;
  typedef enum logic [1:0] {M_IDLE, M_FETCH, M_OFFER, M_WAIT} msg_state_e;

  // Bits in a data frame: start, type, payload, stop.
  function automatic int data_frame_bits(input int dw);
    return dw + 3;
  endfunction

  // Bits in an acknowledge frame: start, type.
  function automatic int ack_frame_bits();
    return 2;
  endfunction

  // True when the byte now being acknowledged is the last of the message.
  function automatic logic is_final_byte(input int unsigned remaining);
    return remaining == 1;
  endfunction

endpackage

// File: rtl/slink_tx_line.sv
// Outgoing wire serializer: acknowledge frames win over data frames,
// and a frame in progress always runs to its end.
module slink_tx_line
  import slink_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_tick,
  input  logic              ack_req,
  input  logic              data_req,
  input  logic [DATA_W-1:0] data_byte,
  output logic              data_take,
  output logic              ack_start,
  output logic              line_out
);
  localparam int FRAME_W = data_frame_bits(DATA_W);
  localparam int LEFT_W  = $clog2(FRAME_W + 1);
  localparam logic [LEFT_W-1:0] DATA_LEFT = LEFT_W'(FRAME_W - 1);
  localparam logic [LEFT_W-1:0] ACK_LEFT  = LEFT_W'(ack_frame_bits() - 1);

  logic [FRAME_W-2:0] shift_q;
  logic [LEFT_W-1:0]  left_q;
  logic               ack_pend_q;
  logic               line_q;
  logic               idle;
  logic               ack_want;

  assign idle      = (left_q == '0);
  assign ack_want  = ack_pend_q || ack_req;
  assign ack_start = bit_tick && idle && ack_want;
  assign data_take = bit_tick && idle && !ack_want && data_req;
  assign line_out  = line_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_q     <= 1'b0;
      shift_q    <= '0;
      left_q     <= '0;
      ack_pend_q <= 1'b0;
    end else begin
      ack_pend_q <= ack_want && !ack_start;
      if (bit_tick) begin
        if (!idle) begin
          line_q  <= shift_q[0];
          shift_q <= {1'b0, shift_q[FRAME_W-2:1]};
          left_q  <= left_q - LEFT_W'(1);
        end else if (ack_start) begin
          line_q  <= 1'b1;
          shift_q <= '0;
          left_q  <= ACK_LEFT;
        end else if (data_take) begin
          line_q  <= 1'b1;
          shift_q <= {1'b0, data_byte, 1'b1};
          left_q  <= DATA_LEFT;
        end else begin
          line_q  <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/slink_rx_line.sv
// Incoming wire deframer. The payload shift register doubles as the
// staging slot for a byte that cannot yet enter the sink buffer.
module slink_rx_line
  import slink_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_tick,
  input  logic              line_in,
  output logic              data_begin,
  output logic              ack_rx,
  output logic              byte_done,
  output logic [DATA_W-1:0] byte_q
);
  localparam int BIT_W = $clog2(DATA_W);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(DATA_W - 1);

  rx_state_e         st_q;
  logic [BIT_W-1:0]  cnt_q;
  logic [DATA_W-1:0] sh_q;

  assign data_begin = bit_tick && (st_q == RX_TYPE) && line_in;
  assign ack_rx     = bit_tick && (st_q == RX_TYPE) && !line_in;
  assign byte_done  = bit_tick && (st_q == RX_STOP);
  assign byte_q     = sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= RX_IDLE;
      cnt_q <= '0;
      sh_q  <= '0;
    end else if (bit_tick) begin
      case (st_q)
        RX_IDLE: if (line_in) st_q <= RX_TYPE;
        RX_TYPE: begin
          st_q  <= line_in ? RX_DATA : RX_IDLE;
          cnt_q <= '0;
        end
        RX_DATA: begin
          sh_q  <= {line_in, sh_q[DATA_W-1:1]};
          cnt_q <= cnt_q + BIT_W'(1);
          if (cnt_q == LAST_BIT) st_q <= RX_STOP;
        end
        RX_STOP: st_q <= RX_IDLE;
        default: st_q <= RX_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/slink_rx_buf.sv
// One-byte sink buffer plus acknowledge credit: at most one acknowledged
// byte may be waiting for the sink.
module slink_rx_buf #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              data_begin,
  input  logic              byte_done,
  input  logic [DATA_W-1:0] byte_in,
  input  logic              sink_ready,
  output logic              sink_valid,
  output logic [DATA_W-1:0] sink_data,
  output logic              ack_req,
  output logic              acked_held
);
  logic              owed_q, credit_q, staged_q, full_q;
  logic [DATA_W-1:0] data_q;
  logic              accept, move;

  assign accept     = full_q && sink_ready;
  assign ack_req    = (owed_q || data_begin) && (!credit_q || accept);
  assign move       = staged_q && (!full_q || accept);
  assign sink_valid = full_q;
  assign sink_data  = data_q;
  assign acked_held = credit_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      owed_q   <= 1'b0;
      credit_q <= 1'b0;
      staged_q <= 1'b0;
      full_q   <= 1'b0;
      data_q   <= '0;
    end else begin
      owed_q   <= (owed_q || data_begin) && !ack_req;
      credit_q <= ack_req ? 1'b1 : (accept ? 1'b0 : credit_q);
      staged_q <= (staged_q && !move) || byte_done;
      full_q   <= move ? 1'b1 : (accept ? 1'b0 : full_q);
      if (move) data_q <= byte_in;
    end
  end
endmodule

// File: rtl/slink_msg.sv
// Message sequencer: one byte fetched, offered, then held until acknowledged.
module slink_msg
  import slink_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              msg_start,
  input  logic [CNT_W-1:0]  msg_len,
  input  logic              src_valid,
  input  logic [DATA_W-1:0] src_data,
  input  logic              data_take,
  input  logic              ack_rx,
  output logic              src_ready,
  output logic              data_req,
  output logic [DATA_W-1:0] data_byte,
  output logic              msg_done
);
  msg_state_e        st_q;
  logic [CNT_W-1:0]  left_q;
  logic [DATA_W-1:0] byte_q;
  logic              done_q;

  assign src_ready = (st_q == M_FETCH);
  assign data_req  = (st_q == M_OFFER);
  assign data_byte = byte_q;
  assign msg_done  = done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= M_IDLE;
      left_q <= '0;
      byte_q <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (st_q)
        M_IDLE: if (msg_start) begin
          if (msg_len == '0) done_q <= 1'b1;
          else begin
            left_q <= msg_len;
            st_q   <= M_FETCH;
          end
        end
        M_FETCH: if (src_valid) begin
          byte_q <= src_data;
          st_q   <= M_OFFER;
        end
        M_OFFER: if (data_take) st_q <= M_WAIT;
        M_WAIT: if (ack_rx) begin
          if (is_final_byte(int'(left_q))) begin
            done_q <= 1'b1;
            st_q   <= M_IDLE;
          end else begin
            left_q <= left_q - CNT_W'(1);
            st_q   <= M_FETCH;
          end
        end
        default: st_q <= M_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/slink_port.sv
module slink_port #(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_tick,
  input  logic              line_in,
  output logic              line_out,
  input  logic              msg_start,
  input  logic [CNT_W-1:0]  msg_len,
  input  logic              src_valid,
  input  logic [DATA_W-1:0] src_data,
  output logic              src_ready,
  output logic              sink_valid,
  output logic [DATA_W-1:0] sink_data,
  input  logic              sink_ready,
  output logic              msg_done
);
  logic              data_take, ack_start, data_req;
  logic [DATA_W-1:0] data_byte;
  logic              data_begin, ack_rx, byte_done;
  logic [DATA_W-1:0] rx_byte;
  logic              ack_issue, acked_held;

  slink_tx_line #(.DATA_W(DATA_W)) u_tx (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick),
    .ack_req(ack_issue), .data_req(data_req), .data_byte(data_byte),
    .data_take(data_take), .ack_start(ack_start), .line_out(line_out)
  );

  slink_rx_line #(.DATA_W(DATA_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .line_in(line_in),
    .data_begin(data_begin), .ack_rx(ack_rx), .byte_done(byte_done),
    .byte_q(rx_byte)
  );

  slink_rx_buf #(.DATA_W(DATA_W)) u_buf (
    .clk(clk), .rst_n(rst_n), .data_begin(data_begin),
    .byte_done(byte_done), .byte_in(rx_byte), .sink_ready(sink_ready),
    .sink_valid(sink_valid), .sink_data(sink_data),
    .ack_req(ack_issue), .acked_held(acked_held)
  );

  slink_msg #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_msg (
    .clk(clk), .rst_n(rst_n), .msg_start(msg_start), .msg_len(msg_len),
    .src_valid(src_valid), .src_data(src_data), .data_take(data_take),
    .ack_rx(ack_rx), .src_ready(src_ready), .data_req(data_req),
    .data_byte(data_byte), .msg_done(msg_done)
  );
endmodule

// File: rtl/slink_port_chk.sv
module slink_port_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bit_tick,
  input logic              line_out,
  input logic              msg_start,
  input logic              msg_done,
  input logic              sink_valid,
  input logic              sink_ready,
  input logic [DATA_W-1:0] sink_data,
  input logic              data_take,
  input logic              ack_rx,
  input logic              ack_issue,
  input logic              ack_start,
  input logic              acked_held
);
  logic outstanding_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) outstanding_q <= 1'b0;
    else if (data_take) outstanding_q <= 1'b1;
    else if (ack_rx) outstanding_q <= 1'b0;
  end

  // R2
  tick_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(line_out) |-> $past(bit_tick));

  // R3
  one_outstanding_chk: assert property (@(posedge clk) disable iff (!rst_n)
    data_take |-> !outstanding_q);

  // R5
  accept_credit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sink_valid && sink_ready) |-> acked_held);

  // R5
  single_credit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack_issue |-> (!acked_held || (sink_valid && sink_ready)));

  // R6
  done_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    msg_done |-> ($past(ack_rx) || $past(msg_start)));

  // R7
  arb_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack_start |-> !data_take);

  // R9
  sink_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sink_valid && !sink_ready) |=> (sink_valid && $stable(sink_data)));
endmodule

bind slink_port slink_port_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .line_out(line_out),
  .msg_start(msg_start), .msg_done(msg_done), .sink_valid(sink_valid),
  .sink_ready(sink_ready), .sink_data(sink_data), .data_take(data_take),
  .ack_rx(ack_rx), .ack_issue(ack_issue), .ack_start(ack_start),
  .acked_held(acked_held)
);

// File: tb/test_slink_port.sv
module test_slink_port;
  localparam int DW = 8;
  localparam int CW = 16;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n = 1'b0;
  logic tick = 1'b0;
  logic a_line, b_line;
  logic a_start = 1'b0, b_start = 1'b0;
  logic [CW-1:0] a_len = '0, b_len = '0;
  logic a_sv = 1'b0, b_sv = 1'b0;
  logic [DW-1:0] a_sd = '0, b_sd = '0;
  logic a_sr, b_sr, a_kv, b_kv, a_done, b_done;
  logic [DW-1:0] a_kd, b_kd;
  logic a_kr = 1'b0, b_kr = 1'b0;

  slink_port #(.DATA_W(DW), .CNT_W(CW)) i_slink_port (
    .clk(clk), .rst_n(rst_n), .bit_tick(tick), .line_in(b_line), .line_out(a_line),
    .msg_start(a_start), .msg_len(a_len), .src_valid(a_sv), .src_data(a_sd),
    .src_ready(a_sr), .sink_valid(a_kv), .sink_data(a_kd), .sink_ready(a_kr),
    .msg_done(a_done)
  );

  slink_port #(.DATA_W(DW), .CNT_W(CW)) i_slink_port_peer (
    .clk(clk), .rst_n(rst_n), .bit_tick(tick), .line_in(a_line), .line_out(b_line),
    .msg_start(b_start), .msg_len(b_len), .src_valid(b_sv), .src_data(b_sd),
    .src_ready(b_sr), .sink_valid(b_kv), .sink_data(b_kd), .sink_ready(b_kr),
    .msg_done(b_done)
  );

  int n_cmp = 0, n_bad = 0;
  int tdiv = 2, tcnt = 0;
  logic sink_en_a = 1'b1, sink_en_b = 1'b1, fast_ack = 1'b0;

  // reference model state: line decoders, source and sink queues
  int dst[2], dcnt[2], frames[2], acks[2];
  logic [DW-1:0] dsh[2];
  logic last_line[2];
  logic [DW-1:0] srcq_a[$], srcq_b[$], linex_a[$], linex_b[$], sinkx_a[$], sinkx_b[$];
  logic hs_a = 1'b0, hs_b = 1'b0;
  int taken_a = 0, taken_b = 0, dones_a = 0, dones_b = 0, got_a = 0, got_b = 0;

  task automatic chk(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic chk_ge(input string tag, input int act, input int lo);
    n_cmp++;
    if (act < lo) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected>=%0d", tag, act, lo);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  task automatic decode(input int s, input logic bt);
    logic [DW-1:0] exp;
    case (dst[s])
      0: if (bt) dst[s] = 1;
      1: if (bt) begin
           dst[s] = 2; dcnt[s] = 0; frames[s]++;
           chk_ge("R3 ack before next data frame", acks[1-s], frames[s] - 1);
         end else begin
           acks[s]++; dst[s] = 0;
         end
      2: begin
           dsh[s][dcnt[s]] = bt; dcnt[s]++;
           if (dcnt[s] == DW) dst[s] = 3;
         end
      default: begin
        chk("R2 stop bit", int'(bt), 0);
        exp = 'x;
        if (s == 0 && linex_a.size() > 0) exp = linex_a.pop_front();
        else if (s == 1 && linex_b.size() > 0) exp = linex_b.pop_front();
        chk("R2 payload LSB first", int'(dsh[s]), int'(exp));
        if (fast_ack && s == 0) chk("R4 ack before frame end", acks[1], frames[0]);
        dst[s] = 0;
      end
    endcase
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (a_line !== last_line[0] && !tick) chk("R2 edge off tick A", 1, 0);
      if (b_line !== last_line[1] && !tick) chk("R2 edge off tick B", 1, 0);
      if (tick) begin
        decode(0, a_line);
        decode(1, b_line);
      end
      if (a_done) begin
        dones_a++;
        chk("R6 done after final ack", acks[1], taken_a);
      end
      if (b_done) begin
        dones_b++;
        chk("R6 done after final ack peer", acks[0], taken_b);
      end
    end
    last_line[0] = a_line;
    last_line[1] = b_line;
    // sources
    if (hs_a) begin
      linex_a.push_back(srcq_a[0]); sinkx_b.push_back(srcq_a[0]);
      void'(srcq_a.pop_front()); taken_a++;
    end
    if (hs_b) begin
      linex_b.push_back(srcq_b[0]); sinkx_a.push_back(srcq_b[0]);
      void'(srcq_b.pop_front()); taken_b++;
    end
    a_sv = srcq_a.size() > 0; a_sd = a_sv ? srcq_a[0] : '0;
    b_sv = srcq_b.size() > 0; b_sd = b_sv ? srcq_b[0] : '0;
    hs_a = a_sv && a_sr && rst_n;
    hs_b = b_sv && b_sr && rst_n;
    // sinks
    a_kr = sink_en_a; b_kr = sink_en_b;
    if (rst_n && b_kv && b_kr) begin
      got_b++;
      chk("R9 sink order", int'(b_kd), sinkx_b.size() > 0 ? int'(sinkx_b.pop_front()) : -1);
    end
    if (rst_n && a_kv && a_kr) begin
      got_a++;
      chk("R9 sink order peer", int'(a_kd), sinkx_a.size() > 0 ? int'(sinkx_a.pop_front()) : -1);
    end
    tcnt = (tcnt + 1) % tdiv;
    tick = (tcnt == 0);
  end

  task automatic at_drive();
    @(posedge clk); #2;
  endtask

  task automatic load_src(input int side, input int n, input int seed);
    for (int i = 0; i < n; i++) begin
      if (side == 0) srcq_a.push_back(DW'(seed + i * 37));
      else srcq_b.push_back(DW'(seed + i * 53));
    end
  endtask

  task automatic start_msg(input int side, input int len);
    if (side == 0) begin a_start = 1'b1; a_len = CW'(len); end
    else begin b_start = 1'b1; b_len = CW'(len); end
    at_drive();
    a_start = 1'b0; b_start = 1'b0;
  endtask

  task automatic wait_done(input int side, input int target);
    int k = 0;
    while (((side == 0) ? dones_a : dones_b) < target && k < 30000) begin
      at_drive(); k++;
    end
    chk("R6 done count", (side == 0) ? dones_a : dones_b, target);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog all requirements actual=timeout expected=completion");
    summary();
    $finish;
  end

  initial begin
    int f0, t0, a0, d0, g0;
    for (int s = 0; s < 2; s++) begin
      dst[s] = 0; dcnt[s] = 0; frames[s] = 0; acks[s] = 0; dsh[s] = '0; last_line[s] = 1'b0;
    end
    repeat (3) at_drive();
    // R1 reset state
    chk("R1 line low in reset", int'(a_line), 0);
    rst_n = 1'b1;
    at_drive();
    chk("R1 line idle low", int'(a_line | b_line), 0);
    chk("R1 done low", int'(a_done), 0);
    chk("R1 sink_valid low", int'(a_kv | b_kv), 0);
    chk("R1 src_ready low", int'(a_sr | b_sr), 0);

    // streaming one direction, early acknowledge (R2, R3, R4, R8)
    fast_ack = 1'b1;
    load_src(0, 5, 8'h3c);
    start_msg(0, 5);
    wait_done(0, 1);
    repeat (20) at_drive();
    chk("R8 bytes taken", taken_a, 5);
    chk("R9 bytes delivered", got_b, 5);
    chk("R4 ack per byte", acks[1], 5);

    // same at one bit per clock
    tdiv = 1;
    load_src(0, 3, 8'ha5);
    start_msg(0, 3);
    wait_done(0, 2);
    repeat (20) at_drive();
    chk("R9 bytes delivered fast tick", got_b, 8);
    fast_ack = 1'b0;
    tdiv = 2;

    // stalled sink: acknowledge withheld (R5, R9)
    sink_en_b = 1'b0;
    a0 = acks[1];
    load_src(0, 4, 8'h11);
    start_msg(0, 4);
    repeat (300) at_drive();
    chk("R5 only one ack while stalled", acks[1] - a0, 1);
    chk("R5 no done while stalled", dones_a, 2);
    chk("R9 byte held for sink", int'(b_kv), 1);
    chk("R9 held byte value", int'(b_kd), 8'h11);
    chk("R3 second frame sent, third blocked", taken_a, 10);
    sink_en_b = 1'b1;
    wait_done(0, 3);
    repeat (20) at_drive();
    chk("R5 all acked after drain", acks[1] - a0, 4);
    chk("R9 delivered after drain", got_b, 12);

    // both directions at once (R7)
    tdiv = 3;
    load_src(0, 6, 8'h70);
    load_src(1, 6, 8'h05);
    fork
      start_msg(0, 6);
      start_msg(1, 6);
    join
    wait_done(0, 4);
    wait_done(1, 1);
    repeat (40) at_drive();
    chk("R7 forward bytes delivered", got_b, 18);
    chk("R7 reverse bytes delivered", got_a, 6);
    chk("R7 reverse acks", acks[0], 6);
    tdiv = 2;

    // zero length (R6)
    f0 = frames[0];
    start_msg(0, 0);
    chk("R6 zero length done pulse", int'(a_done), 1);
    repeat (40) at_drive();
    chk("R6 zero length no frame", frames[0] - f0, 0);
    chk("R6 zero length single pulse", dones_a, 5);

    // start while busy is ignored (R8)
    t0 = taken_a; d0 = dones_a; g0 = got_b;
    load_src(0, 3, 8'hc1);
    start_msg(0, 3);
    repeat (10) at_drive();
    start_msg(0, 7);
    wait_done(0, d0 + 1);
    repeat (400) at_drive();
    chk("R8 ignored start bytes", taken_a - t0, 3);
    chk("R8 ignored start dones", dones_a - d0, 1);
    chk("R8 delivered", got_b - g0, 3);
    chk("R8 source not over-read", int'(a_sr), 0);

    summary();
    $finish;
  end
endmodule